// File: doc/BRIEF.md
# Debug Exception Cause Unit

This unit sits beside the execution pipeline of a processor core and decides, once per clock, whether the core must take its debug exception. It gathers four kinds of cause: breakpoint match strobes, the single-step flag at instruction completion, a switch into a task whose trap bit is set, and an attempt to touch the debug registers while access guarding is on. It then records every cause in a sticky status register that the handler reads and clears.

A separate comparator produces the breakpoint match strobes. The unit qualifies them with per-breakpoint local and global enables held in its own control register. It masks instruction breakpoints while the resume flag is up. It classifies the exception as a fault, taken before the instruction, or as a trap, taken after it. The unit also owns the guard bit, which it drops on handler entry after a guarded access, and the local enables, which it drops on every task switch.

Top module: `dbg_excp_unit`

## Requirements
- R1: After reset the status register, the control register, the resume flag, the exception request and the fault indication are all zero.
- R2: A breakpoint raises the exception request (one cycle after the match, lasting one cycle) only if its local or global enable is set; a match on disabled breakpoints alone raises nothing and leaves the status register unchanged.
- R3: When at least one enabled breakpoint matches, the status flag of every breakpoint matching in that cycle is set, including disabled ones.
- R4: An enabled instruction breakpoint (type input 1) raises a fault (fault output 1); an enabled data breakpoint (type input 0) raises a trap (fault output 0).
- R5: Hardware only sets status flags and never clears them. A software write replaces the register, and a flag set by hardware in the same cycle survives that write.
- R6: A debug-register access attempt while the guard bit (control bit 2*NUM_BP) is 1 raises a fault, sets the access flag and clears the guard bit. With the guard bit at 0 the attempt does nothing.
- R7: The single-step flag at instruction completion raises a trap and sets the step flag; the flag without completion does nothing.
- R8: Every task switch clears the local enables (control bits NUM_BP-1..0) and keeps the global enables (bits 2*NUM_BP-1..NUM_BP). If the new task's trap bit is set, it also raises a trap and sets the task flag.
- R9: While the resume flag is 1, instruction breakpoint matches are ignored, with no exception and no status flag, while data matches still act. The flag is set by its set strobe and cleared when an instruction completes.
- R10: Causes that coincide in one cycle set all their flags together, and any fault cause makes the exception a fault.
- R11: Status layout: breakpoint flags in bits 0 to NUM_BP-1, access flag bit 13, step flag bit 14, task flag bit 15; every other bit reads 0 even after writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bp_hit_i | input | NUM_BP | Breakpoint match strobes |
| bp_is_exec_i | input | NUM_BP | Per breakpoint: 1 instruction, 0 data |
| tf_i | input | 1 | Single-step flag |
| insn_done_i | input | 1 | Instruction completed this cycle |
| task_sw_i | input | 1 | Task switch strobe |
| task_trap_i | input | 1 | Trap bit of the task being entered |
| dr_access_i | input | 1 | Debug register access attempt |
| rf_set_i | input | 1 | Sets the resume flag |
| ctl_we_i | input | 1 | Control register write |
| ctl_wdata_i | input | 2*NUM_BP+1 | Control write data: local enables, global enables, guard |
| sts_we_i | input | 1 | Status register write |
| sts_wdata_i | input | 32 | Status write data |
| ctl_o | output | 2*NUM_BP+1 | Control register |
| rf_o | output | 1 | Resume flag |
| sts_o | output | 32 | Status register |
| exc_req_o | output | 1 | Debug exception request pulse |
| exc_fault_o | output | 1 | 1 fault, 0 trap, valid with the request |

## Verification
The bench drives matches on disabled breakpoints next to enabled ones. A design that gated the flags by enable would miss the disabled flag, and one that fired on any match would raise a spurious exception. It writes zero to the status register in the same cycle as a hit, to catch a design that lets software win. It repeats a guarded access after the guard has dropped, to expose a guard that never clears. It also mixes instruction and data matches under the resume flag and stacks a data trap with a guarded-access fault, which a design would misclassify if it suppressed data hits or ranked traps above faults.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int STS_W  = 32;
  localparam int BD_POS = 13;
  localparam int BS_POS = 14;
  localparam int BT_POS = 15;

  function automatic logic [STS_W-1:0] sts_mask(int n_bp);
    logic [STS_W-1:0] m;
    m = '0;
    for (int i = 0; i < n_bp; i++) m[i] = 1'b1;
    m[BD_POS] = 1'b1;
    m[BS_POS] = 1'b1;
    m[BT_POS] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dbg_bp_eval.sv
module dbg_bp_eval #(
  parameter int NUM_BP = 4
) (
  input  logic [NUM_BP-1:0] hit_i,
  input  logic [NUM_BP-1:0] is_exec_i,
  input  logic [NUM_BP-1:0] en_i,
  input  logic              rf_i,
  output logic [NUM_BP-1:0] live_o,
  output logic              fire_o,
  output logic              fire_exec_o
);
  logic [NUM_BP-1:0] armed;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    // resume flag hides instruction matches only
    assign live_o[i] = hit_i[i] & ~(is_exec_i[i] & rf_i);
    assign armed[i]  = live_o[i] & en_i[i];
  end

  assign fire_o      = |armed;
  assign fire_exec_o = |(armed & is_exec_i);
endmodule

// File: rtl/dbg_cause_merge.sv
module dbg_cause_merge
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4
) (
  input  logic [NUM_BP-1:0] live_i,
  input  logic              fire_i,
  input  logic              fire_exec_i,
  input  logic              gd_viol_i,
  input  logic              step_i,
  input  logic              task_i,
  output logic [STS_W-1:0]  set_o,
  output logic              raise_o,
  output logic              fault_o
);
  always_comb begin
    set_o = '0;
    if (fire_i) set_o[NUM_BP-1:0] = live_i;
    set_o[BD_POS] = gd_viol_i;
    set_o[BS_POS] = step_i;
    set_o[BT_POS] = task_i;
  end

  assign raise_o = fire_i | gd_viol_i | step_i | task_i;
  assign fault_o = fire_exec_i | gd_viol_i;
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg #(
  parameter int NUM_BP = 4,
  localparam int CTL_W = 2 * NUM_BP + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             task_sw_i,
  input  logic             gd_clr_i,
  input  logic             rf_set_i,
  input  logic             insn_done_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             rf_o
);
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = we_i ? wdata_i : ctl_o;
    // hardware clears override a same-cycle write
    if (task_sw_i) ctl_d[NUM_BP-1:0] = '0;
    if (gd_clr_i)  ctl_d[2*NUM_BP] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      rf_o  <= 1'b0;
    end else begin
      ctl_o <= ctl_d;
      if (rf_set_i)         rf_o <= 1'b1;
      else if (insn_done_i) rf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_sts_reg.sv
module dbg_sts_reg
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [STS_W-1:0] wdata_i,
  input  logic [STS_W-1:0] set_i,
  output logic [STS_W-1:0] sts_o
);
  localparam logic [STS_W-1:0] MASK = sts_mask(NUM_BP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= ((we_i ? wdata_i : sts_o) | set_i) & MASK;
  end
endmodule

// File: rtl/dbg_excp_unit.sv
module dbg_excp_unit
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4,
  localparam int CTL_W = 2 * NUM_BP + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_BP-1:0] bp_hit_i,
  input  logic [NUM_BP-1:0] bp_is_exec_i,
  input  logic              tf_i,
  input  logic              insn_done_i,
  input  logic              task_sw_i,
  input  logic              task_trap_i,
  input  logic              dr_access_i,
  input  logic              rf_set_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              sts_we_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              rf_o,
  output logic [STS_W-1:0]  sts_o,
  output logic              exc_req_o,
  output logic              exc_fault_o
);
  logic [NUM_BP-1:0] en, live;
  logic              fire, fire_exec, gd_viol, step_evt, task_evt, raise, fault;
  logic [STS_W-1:0]  set_vec;

  assign en       = ctl_o[NUM_BP-1:0] | ctl_o[2*NUM_BP-1:NUM_BP];
  assign gd_viol  = dr_access_i & ctl_o[2*NUM_BP];
  assign step_evt = tf_i & insn_done_i;
  assign task_evt = task_sw_i & task_trap_i;

  dbg_bp_eval #(.NUM_BP(NUM_BP)) u_eval (
    .hit_i(bp_hit_i), .is_exec_i(bp_is_exec_i), .en_i(en), .rf_i(rf_o),
    .live_o(live), .fire_o(fire), .fire_exec_o(fire_exec)
  );

  dbg_cause_merge #(.NUM_BP(NUM_BP)) u_merge (
    .live_i(live), .fire_i(fire), .fire_exec_i(fire_exec),
    .gd_viol_i(gd_viol), .step_i(step_evt), .task_i(task_evt),
    .set_o(set_vec), .raise_o(raise), .fault_o(fault)
  );

  dbg_ctl_reg #(.NUM_BP(NUM_BP)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctl_we_i), .wdata_i(ctl_wdata_i),
    .task_sw_i(task_sw_i), .gd_clr_i(gd_viol), .rf_set_i(rf_set_i),
    .insn_done_i(insn_done_i), .ctl_o(ctl_o), .rf_o(rf_o)
  );

  dbg_sts_reg #(.NUM_BP(NUM_BP)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sts_we_i), .wdata_i(sts_wdata_i),
    .set_i(set_vec), .sts_o(sts_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_req_o   <= 1'b0;
      exc_fault_o <= 1'b0;
    end else begin
      exc_req_o   <= raise;
      exc_fault_o <= raise & fault;
    end
  end
endmodule

// File: rtl/dbg_excp_chk.sv
module dbg_excp_chk
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4,
  localparam int CTL_W = 2 * NUM_BP + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sts_we_i,
  input logic             dr_access_i,
  input logic             task_sw_i,
  input logic [CTL_W-1:0] ctl_o,
  input logic [STS_W-1:0] sts_o,
  input logic             exc_req_o,
  input logic             exc_fault_o
);
  localparam logic [STS_W-1:0] MASK = sts_mask(NUM_BP);

  assert_req_has_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> ($countones(sts_o) > 0));

  assert_fault_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fault_o |-> exc_req_o);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_we_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

  assert_gd_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_access_i && ctl_o[2*NUM_BP]) |=>
      (exc_req_o && exc_fault_o && sts_o[BD_POS] && !ctl_o[2*NUM_BP]));

  assert_local_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_sw_i |=> (ctl_o[NUM_BP-1:0] == '0));

  assert_layout_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o & ~MASK) == '0);
endmodule

bind dbg_excp_unit dbg_excp_chk #(.NUM_BP(NUM_BP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sts_we_i(sts_we_i), .dr_access_i(dr_access_i),
  .task_sw_i(task_sw_i), .ctl_o(ctl_o), .sts_o(sts_o),
  .exc_req_o(exc_req_o), .exc_fault_o(exc_fault_o)
);

// File: tb/sim_dbg_excp_unit.sv
module sim_dbg_excp_unit;
  localparam int NB = 4;
  localparam int CW = 2 * NB + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NB-1:0] bp_hit = '0, bp_is_exec = '0;
  logic tf = 0, insn_done = 0, task_sw = 0, task_trap = 0, dr_access = 0, rf_set = 0;
  logic ctl_we = 0, sts_we = 0;
  logic [CW-1:0] ctl_wdata = '0;
  logic [31:0] sts_wdata = '0;
  logic [CW-1:0] ctl;
  logic rf, exc_req, exc_fault;
  logic [31:0] sts;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_excp_unit #(.NUM_BP(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bp_hit_i(bp_hit), .bp_is_exec_i(bp_is_exec),
    .tf_i(tf), .insn_done_i(insn_done), .task_sw_i(task_sw), .task_trap_i(task_trap),
    .dr_access_i(dr_access), .rf_set_i(rf_set), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wdata), .ctl_o(ctl), .rf_o(rf), .sts_o(sts),
    .exc_req_o(exc_req), .exc_fault_o(exc_fault)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    bp_hit = '0; bp_is_exec = '0; tf = 0; insn_done = 0; task_sw = 0; task_trap = 0;
    dr_access = 0; rf_set = 0; ctl_we = 0; sts_we = 0;
  endtask

  // apply the driven inputs for one edge, then drop them
  task automatic fire();
    tick(); idle();
  endtask

  task automatic wr_ctl(logic [CW-1:0] v);
    ctl_we = 1; ctl_wdata = v; fire();
  endtask

  task automatic wr_sts(logic [31:0] v);
    sts_we = 1; sts_wdata = v; fire();
  endtask

  task automatic t_reset();
    chk("R1 sts", sts, 0);
    chk("R1 ctl", 32'(ctl), 0);
    chk("R1 rf", 32'(rf), 0);
    chk("R1 req", {exc_fault, exc_req}, 0);
  endtask

  task automatic t_disabled();
    wr_ctl('0);
    bp_hit = 4'b0010; fire();
    chk("R2 disabled no req", 32'(exc_req), 0);
    chk("R2 disabled no flag", sts, 0);
  endtask

  task automatic t_data_bp();
    wr_ctl(9'h040);                      // global enable bp2
    bp_hit = 4'b0101; fire();
    chk("R2 req", 32'(exc_req), 1);
    chk("R3 disabled flag too", sts, 32'h5);
    chk("R4 data trap", 32'(exc_fault), 0);
    tick();
    chk("R2 one-cycle pulse", 32'(exc_req), 0);
    wr_sts(32'hFFFF_FFFF);
    chk("R11 mask", sts, 32'h0000_E00F);
    wr_sts(0);
    chk("R5 sw clear", sts, 0);
  endtask

  task automatic t_exec_bp();
    wr_ctl(9'h001);
    bp_hit = 4'b0001; bp_is_exec = 4'b0001; fire();
    chk("R4 exec fault", {exc_fault, exc_req}, 32'h3);
    tick();
    chk("R5 sticky", sts, 32'h1);
    wr_sts(0);
    bp_hit = 4'b0001; sts_we = 1; sts_wdata = 0; fire();
    chk("R5 hw over write", sts, 32'h1);
    wr_sts(0);
  endtask

  task automatic t_guard();
    wr_ctl(9'h100);
    dr_access = 1; fire();
    chk("R6 fault", {exc_fault, exc_req}, 32'h3);
    chk("R6 BD", sts, 32'h2000);
    chk("R6 guard cleared", 32'(ctl), 0);
    wr_sts(0);
    dr_access = 1; fire();
    chk("R6 unguarded no req", 32'(exc_req), 0);
    chk("R6 unguarded no flag", sts, 0);
  endtask

  task automatic t_step();
    tf = 1; fire();
    chk("R7 no completion", 32'(exc_req), 0);
    tf = 1; insn_done = 1; fire();
    chk("R7 trap", {exc_fault, exc_req}, 32'h1);
    chk("R7 BS", sts, 32'h4000);
    wr_sts(0);
  endtask

  task automatic t_task();
    wr_ctl(9'h0FF);
    task_sw = 1; task_trap = 1; fire();
    chk("R8 trap", {exc_fault, exc_req}, 32'h1);
    chk("R8 BT", sts, 32'h8000);
    chk("R8 local cleared", 32'(ctl), 32'h0F0);
    wr_sts(0);
    wr_ctl(9'h0FF);
    task_sw = 1; fire();
    chk("R8 no trap bit", 32'(exc_req), 0);
    chk("R8 local cleared again", 32'(ctl), 32'h0F0);
  endtask

  task automatic t_resume();
    wr_ctl(9'h00F);
    rf_set = 1; fire();
    chk("R9 rf set", 32'(rf), 1);
    bp_hit = 4'b0010; bp_is_exec = 4'b0010; fire();
    chk("R9 exec ignored", 32'(exc_req), 0);
    chk("R9 exec no flag", sts, 0);
    bp_hit = 4'b0010; fire();
    chk("R9 data still acts", {exc_fault, exc_req}, 32'h1);
    wr_sts(0);
    insn_done = 1; fire();
    chk("R9 rf cleared", 32'(rf), 0);
    bp_hit = 4'b0010; bp_is_exec = 4'b0010; fire();
    chk("R9 exec after rf", {exc_fault, exc_req}, 32'h3);
    wr_sts(0);
  endtask

  task automatic t_coincide();
    wr_ctl(9'h180);                      // guard + global bp3
    bp_hit = 4'b1000; tf = 1; insn_done = 1; dr_access = 1; fire();
    chk("R10 all flags", sts, 32'h6008);
    chk("R10 fault wins", {exc_fault, exc_req}, 32'h3);
    wr_sts(0);
  endtask

  initial begin
    idle();
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
    tick();
    t_reset();
    t_disabled();
    t_data_bp();
    t_exec_bp();
    t_guard();
    t_step();
    t_task();
    t_resume();
    t_coincide();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule